// File: doc/BRIEF.md
# Prefixed Shift, Rotate and Bit-Manipulation Unit

This block is the purely combinational datapath slice that executes the byte-oriented bit-manipulation group of a small 8-bit processor core. It takes one operand and the current flag byte. A two-bit group field selects one of four classes: rotate/shift, single-bit test, single-bit clear or single-bit set. A three-bit selector is read as the rotate/shift kind within the first class, and as a bit index within the other three. The block returns the new operand value, the new flag byte, and a strobe that tells the register file whether the result should be written back.

The core fetches the operand from a register or from memory before the block sees it, and stores the result afterwards. An accumulator-mode input lets the same rotate hardware serve the short accumulator-only rotate instructions. Those instructions always leave the zero flag clear instead of deriving it from the result. Bits 3:0 of the flag byte are not architectural flags, and the block passes them through untouched.

Top module: `bitmanip_unit`

## Requirements
- R1: With group code 0, selector 0 rotates left and selector 1 rotates right, without carry. In both cases the bit leaving the byte re-enters at the opposite end and is also copied to C. Flag byte layout: Z is bit 7, N is bit 6, H is bit 5, C is bit 4.
- R2: With group code 0, selector 2 rotates left through carry and selector 3 rotates right through carry. The incoming C fills the vacated end and the outgoing bit becomes the new C.
- R3: With group code 0, selector 4 shifts left and fills bit 0 with 0. Selector 5 shifts right and keeps bit 7. Selector 7 shifts right and fills bit 7 with 0. Each of the three moves the shifted-out bit into C.
- R4: With group code 0, selector 6 exchanges the upper and lower nibbles and clears C.
- R5: Every group-0 operation clears N and H. When accumulator mode is low, Z is set exactly when the produced result is zero.
- R6: When accumulator mode is high, a group-0 operation drives Z to 0 whatever the result is. For the other groups, accumulator mode has no effect.
- R7: Group code 1 tests operand bit n, where n is the selector. Z becomes the inverse of that bit, H is set, N is cleared and C is kept. The result output carries the unmodified operand and the write-back strobe is low.
- R8: Group code 2 clears operand bit n and group code 3 sets operand bit n. All other bits are unchanged and the flag byte is returned unchanged.
- R9: Flag bits 3:0 appear at the output exactly as they arrive, for every operation.
- R10: The write-back strobe is high for group codes 0, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 8 | Byte to be manipulated |
| group_i | input | 2 | Operation class: 0 rotate/shift, 1 test, 2 clear, 3 set |
| sel_i | input | 3 | Rotate/shift kind for group 0, bit index otherwise |
| flags_i | input | 8 | Current flag byte |
| acc_mode_i | input | 1 | Accumulator-form rotate: forces Z low in group 0 |
| result_o | output | 8 | Manipulated byte |
| flags_o | output | 8 | Next flag byte |
| result_valid_o | output | 1 | High when the result should be written back |

## Verification
The block holds no state, so any decode or steering fault shows up at the ports in the same evaluation in which the offending inputs are applied. It never appears later. A mis-routed carry shows as a wrong fill bit in the result or a wrong C. A wrong class decode shows as flags that change during a bit clear or set, or as a write-back strobe raised on a bit test. Table vectors aim at the edge bits of every rotate and shift, and at results that are zero in both the normal and the accumulator form. Sweeps over every bit index catch a mask that is off by one position.

// File: rtl/bitmanip_pkg.sv
package bitmanip_pkg;

  // Flag byte bit positions; the surrounding core decodes these.
  localparam int unsigned FLAG_Z = 7;
  localparam int unsigned FLAG_N = 6;
  localparam int unsigned FLAG_H = 5;
  localparam int unsigned FLAG_C = 4;
  localparam int unsigned FLAG_W = 8;

  typedef enum logic [1:0] {
    GRP_SHIFT = 2'd0,
    GRP_TEST  = 2'd1,
    GRP_CLEAR = 2'd2,
    GRP_SET   = 2'd3
  } grp_e;

  typedef enum logic [2:0] {
    SH_ROT_L      = 3'd0,
    SH_ROT_R      = 3'd1,
    SH_ROT_L_CY   = 3'd2,
    SH_ROT_R_CY   = 3'd3,
    SH_ARITH_L    = 3'd4,
    SH_ARITH_R    = 3'd5,
    SH_NIB_XCHG   = 3'd6,
    SH_LOGIC_R    = 3'd7
  } shop_e;

endpackage

// File: rtl/bm_shifter.sv
module bm_shifter
  import bitmanip_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [2:0]       kind_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] data_o,
  output logic             carry_o
);

  localparam int unsigned HALF = WIDTH / 2;
  localparam int unsigned MSB  = WIDTH - 1;

  logic msb_w;
  logic lsb_w;

  assign msb_w = data_i[MSB];
  assign lsb_w = data_i[0];

  always_comb begin
    data_o  = data_i;
    carry_o = 1'b0;
    unique case (shop_e'(kind_i))
      SH_ROT_L: begin
        data_o  = {data_i[MSB-1:0], msb_w};
        carry_o = msb_w;
      end
      SH_ROT_R: begin
        data_o  = {lsb_w, data_i[MSB:1]};
        carry_o = lsb_w;
      end
      SH_ROT_L_CY: begin
        data_o  = {data_i[MSB-1:0], carry_i};
        carry_o = msb_w;
      end
      SH_ROT_R_CY: begin
        data_o  = {carry_i, data_i[MSB:1]};
        carry_o = lsb_w;
      end
      SH_ARITH_L: begin
        data_o  = {data_i[MSB-1:0], 1'b0};
        carry_o = msb_w;
      end
      SH_ARITH_R: begin
        data_o  = {msb_w, data_i[MSB:1]};
        carry_o = lsb_w;
      end
      SH_NIB_XCHG: begin
        data_o  = {data_i[HALF-1:0], data_i[MSB:HALF]};
        carry_o = 1'b0;
      end
      SH_LOGIC_R: begin
        data_o  = {1'b0, data_i[MSB:1]};
        carry_o = lsb_w;
      end
      default: begin
        data_o  = data_i;
        carry_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/bm_bitop.sv
module bm_bitop #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned IDXW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [IDXW-1:0]  index_i,
  input  logic             set_not_clear_i,
  output logic [WIDTH-1:0] data_o,
  output logic             tested_o
);

  logic [WIDTH-1:0] mask_w;

  // One-hot mask, one decoder leg per bit position.
  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_mask
    assign mask_w[gi] = (index_i == IDXW'(gi));
  end

  assign tested_o = |(data_i & mask_w);
  assign data_o   = set_not_clear_i ? (data_i | mask_w) : (data_i & ~mask_w);

endmodule

// File: rtl/bm_flags.sv
module bm_flags
  import bitmanip_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [1:0]        group_i,
  input  logic              acc_mode_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [WIDTH-1:0]  shift_data_i,
  input  logic              shift_carry_i,
  input  logic              tested_i,
  output logic [FLAG_W-1:0] flags_o
);

  logic shift_zero_w;

  assign shift_zero_w = (shift_data_i == '0);

  always_comb begin
    flags_o = flags_i;
    unique case (grp_e'(group_i))
      GRP_SHIFT: begin
        flags_o[FLAG_Z] = shift_zero_w & ~acc_mode_i;
        flags_o[FLAG_N] = 1'b0;
        flags_o[FLAG_H] = 1'b0;
        flags_o[FLAG_C] = shift_carry_i;
      end
      GRP_TEST: begin
        flags_o[FLAG_Z] = ~tested_i;
        flags_o[FLAG_N] = 1'b0;
        flags_o[FLAG_H] = 1'b1;
      end
      default: flags_o = flags_i;
    endcase
  end

endmodule

// File: rtl/bitmanip_unit.sv
module bitmanip_unit
  import bitmanip_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned IDXW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0]  operand_i,
  input  logic [1:0]        group_i,
  input  logic [IDXW-1:0]   sel_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              acc_mode_i,
  output logic [WIDTH-1:0]  result_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              result_valid_o
);

  logic [WIDTH-1:0] shift_data_w;
  logic             shift_carry_w;
  logic [WIDTH-1:0] bit_data_w;
  logic             tested_w;

  bm_shifter #(.WIDTH(WIDTH)) u_shift (
    .data_i  (operand_i),
    .kind_i  (sel_i[2:0]),
    .carry_i (flags_i[FLAG_C]),
    .data_o  (shift_data_w),
    .carry_o (shift_carry_w)
  );

  bm_bitop #(.WIDTH(WIDTH), .IDXW(IDXW)) u_bit (
    .data_i          (operand_i),
    .index_i         (sel_i),
    .set_not_clear_i (group_i[0]),
    .data_o          (bit_data_w),
    .tested_o        (tested_w)
  );

  bm_flags #(.WIDTH(WIDTH)) u_flags (
    .group_i       (group_i),
    .acc_mode_i    (acc_mode_i),
    .flags_i       (flags_i),
    .shift_data_i  (shift_data_w),
    .shift_carry_i (shift_carry_w),
    .tested_i      (tested_w),
    .flags_o       (flags_o)
  );

  always_comb begin
    unique case (grp_e'(group_i))
      GRP_SHIFT: result_o = shift_data_w;
      GRP_TEST:  result_o = operand_i;
      default:   result_o = bit_data_w;
    endcase
  end

  assign result_valid_o = (grp_e'(group_i) != GRP_TEST);

endmodule

// File: rtl/bitmanip_unit_chk.sv
module bitmanip_unit_chk
  import bitmanip_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned IDXW  = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0]  operand_i,
  input logic [1:0]        group_i,
  input logic [IDXW-1:0]   sel_i,
  input logic [FLAG_W-1:0] flags_i,
  input logic              acc_mode_i,
  input logic [WIDTH-1:0]  result_o,
  input logic [FLAG_W-1:0] flags_o,
  input logic              result_valid_o
);

  logic known_w;
  assign known_w = !$isunknown({operand_i, group_i, sel_i, flags_i, acc_mode_i});

  always_comb begin
    if (known_w) begin
      p_low_nibble_pass_r9: assert (flags_o[3:0] == flags_i[3:0])
        else $error("low flag nibble altered");
      if (group_i == 2'd0) begin
        p_nh_cleared_r5: assert (!flags_o[FLAG_N] && !flags_o[FLAG_H])
          else $error("N/H not cleared by rotate/shift");
        if (acc_mode_i) begin
          p_acc_zero_low_r6: assert (!flags_o[FLAG_Z])
            else $error("Z set in accumulator mode");
        end else begin
          p_zero_tracks_result_r5: assert (flags_o[FLAG_Z] == (result_o == '0))
            else $error("Z disagrees with result");
        end
      end
      if (group_i == 2'd1) begin
        p_test_keeps_carry_r7: assert (flags_o[FLAG_C] == flags_i[FLAG_C] && !result_valid_o)
          else $error("bit test altered C or strobed write-back");
      end
      if (group_i[1]) begin
        p_flags_hold_r8: assert (flags_o == flags_i)
          else $error("bit clear/set altered flags");
        p_single_bit_r8: assert ($countones(result_o ^ operand_i) <= 1)
          else $error("bit clear/set touched more than one bit");
      end
      if (group_i != 2'd1) begin
        p_valid_high_r10: assert (result_valid_o)
          else $error("write-back strobe low");
      end
    end
  end

endmodule

bind bitmanip_unit bitmanip_unit_chk #(.WIDTH(WIDTH), .IDXW(IDXW)) u_chk (
  .operand_i      (operand_i),
  .group_i        (group_i),
  .sel_i          (sel_i),
  .flags_i        (flags_i),
  .acc_mode_i     (acc_mode_i),
  .result_o       (result_o),
  .flags_o        (flags_o),
  .result_valid_o (result_valid_o)
);

// File: tb/tb_bitmanip_unit.sv
module tb_bitmanip_unit;

  logic       clk;
  logic [7:0] operand_i;
  logic [1:0] group_i;
  logic [2:0] sel_i;
  logic [7:0] flags_i;
  logic       acc_mode_i;
  logic [7:0] result_o;
  logic [7:0] flags_o;
  logic       result_valid_o;

  int n_checks = 0;
  int n_fail   = 0;

  bitmanip_unit dut (
    .operand_i      (operand_i),
    .group_i        (group_i),
    .sel_i          (sel_i),
    .flags_i        (flags_i),
    .acc_mode_i     (acc_mode_i),
    .result_o       (result_o),
    .flags_o        (flags_o),
    .result_valid_o (result_valid_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {group, sel, acc, flags_in, operand, exp_result, exp_flags, exp_valid, req}
  localparam int NV = 19;
  localparam logic [42:0] VEC [NV] = '{
    {2'd0, 3'd0, 1'b0, 8'h00, 8'h85, 8'h0B, 8'h10, 1'b1, 4'd1},  // R1 rotate left
    {2'd0, 3'd1, 1'b0, 8'h00, 8'h01, 8'h80, 8'h10, 1'b1, 4'd1},  // R1 rotate right
    {2'd0, 3'd2, 1'b0, 8'h00, 8'h80, 8'h00, 8'h90, 1'b1, 4'd2},  // R2 through carry, zero
    {2'd0, 3'd2, 1'b0, 8'h10, 8'h01, 8'h03, 8'h00, 1'b1, 4'd2},  // R2 old C enters bit 0
    {2'd0, 3'd3, 1'b0, 8'h10, 8'h01, 8'h80, 8'h10, 1'b1, 4'd2},  // R2 old C enters bit 7
    {2'd0, 3'd3, 1'b0, 8'h60, 8'h02, 8'h01, 8'h00, 1'b1, 4'd5},  // R5 N,H cleared
    {2'd0, 3'd4, 1'b0, 8'h00, 8'hC1, 8'h82, 8'h10, 1'b1, 4'd3},  // R3 left shift
    {2'd0, 3'd5, 1'b0, 8'h00, 8'h81, 8'hC0, 8'h10, 1'b1, 4'd3},  // R3 sign-keeping shift
    {2'd0, 3'd7, 1'b0, 8'h0A, 8'h81, 8'h40, 8'h1A, 1'b1, 4'd3},  // R3 logical right, R9
    {2'd0, 3'd6, 1'b0, 8'h70, 8'h3C, 8'hC3, 8'h00, 1'b1, 4'd4},  // R4 nibble exchange
    {2'd0, 3'd6, 1'b0, 8'h10, 8'h00, 8'h00, 8'h80, 1'b1, 4'd4},  // R4 zero result
    {2'd0, 3'd7, 1'b1, 8'h00, 8'h01, 8'h00, 8'h10, 1'b1, 4'd6},  // R6 Z forced low
    {2'd0, 3'd0, 1'b1, 8'h80, 8'h00, 8'h00, 8'h00, 1'b1, 4'd6},  // R6 Z forced low
    {2'd1, 3'd7, 1'b0, 8'h10, 8'h7F, 8'h7F, 8'hB0, 1'b0, 4'd7},  // R7 bit clear -> Z
    {2'd1, 3'd0, 1'b0, 8'h45, 8'h01, 8'h01, 8'h25, 1'b0, 4'd7},  // R7 bit set, R9
    {2'd2, 3'd3, 1'b0, 8'hF5, 8'hFF, 8'hF7, 8'hF5, 1'b1, 4'd8},  // R8 clear bit 3
    {2'd3, 3'd6, 1'b0, 8'h00, 8'h00, 8'h40, 8'h00, 1'b1, 4'd8},  // R8 set bit 6
    {2'd3, 3'd2, 1'b1, 8'h80, 8'h04, 8'h04, 8'h80, 1'b1, 4'd6},  // R6 no effect outside group 0
    {2'd1, 3'd3, 1'b1, 8'h00, 8'h00, 8'h00, 8'hA0, 1'b0, 4'd10}  // R10 strobe low on test
  };

  task automatic check(input string req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] g, input logic [2:0] s, input logic a,
                       input logic [7:0] f, input logic [7:0] op);
    @(negedge clk);
    group_i = g; sel_i = s; acc_mode_i = a; flags_i = f; operand_i = op;
    @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    #100000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    operand_i = 8'h00; group_i = 2'd0; sel_i = 3'd0; flags_i = 8'h00; acc_mode_i = 1'b0;

    // Idle state check: zero operand rotated gives zero with Z (R5).
    apply(2'd0, 3'd0, 1'b0, 8'h00, 8'h00);
    check("R5", "idle flags", flags_o, 8'h80);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VEC[i][3:0]);
      apply(VEC[i][42:41], VEC[i][40:38], VEC[i][37], VEC[i][36:29], VEC[i][28:21]);
      check(rq, "result", result_o, VEC[i][20:13]);
      check(rq, "flags", flags_o, VEC[i][12:5]);
      check(rq, "valid", {7'd0, result_valid_o}, {7'd0, VEC[i][4]});
    end

    // Sweep of every bit index for clear, set and test (R8, R7).
    for (int b = 0; b < 8; b++) begin
      logic [7:0] m;
      m = 8'(1 << b);
      apply(2'd3, 3'(b), 1'b0, 8'h5A, 8'h00);
      check("R8", "set sweep", result_o, m);
      check("R8", "set flags", flags_o, 8'h5A);
      apply(2'd2, 3'(b), 1'b0, 8'hA5, 8'hFF);
      check("R8", "clear sweep", result_o, ~m);
      apply(2'd1, 3'(b), 1'b0, 8'h00, m);
      check("R7", "test sweep", flags_o, 8'h20);
    end

    // Rotate left eight times returns the original byte (R1).
    begin
      logic [7:0] v;
      v = 8'hB4;
      for (int k = 0; k < 8; k++) begin
        apply(2'd0, 3'd0, 1'b0, 8'h00, v);
        v = result_o;
      end
      check("R1", "eight rotations", v, 8'hB4);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule